// File: doc/BRIEF.md
# Segmented Current-Steering DAC Input Decoder

This block sits in front of the switch matrix of a 14-bit current-steering digital-to-analog converter. Each sample is a straight-binary word. The block splits it into a coarse part and a fine part. The five most significant bits become a 31-line thermometer code, and each of those lines drives one equally weighted unit segment worth 512 LSB. The nine least significant bits stay binary-weighted. Every control line leaves the block as a complementary pair. The A line steers that source's current to the true output and the B line steers it to the complementary output.

The thermometer decode runs combinationally ahead of one edge-triggered register. All segment and binary controls therefore change together on the rising sample-clock edge, and no decode skew reaches the current switches. A high sleep input freezes the registered controls. A synchronous reset loads the all-zeros code, which puts all current on the B side.

Top module: `segdac_decoder`

## Requirements
- R1: With m the value of code bits 13..9 (bit 13 most significant), after the capturing edge segment line k of seg_a_o (k = 0..30) is 1 exactly when m > k, so seg_a_o is filled from bit 0 upward.
- R2: After the capturing edge lsb_a_o equals code bits 8..0 unchanged, with bit 0 of lsb_a_o carrying weight 1 and bit 8 carrying weight 256.
- R3: Every B output is the bitwise inverse of its A partner: seg_b_o == ~seg_a_o and lsb_b_o == ~lsb_a_o.
- R4: Outputs change only on a rising clock edge. An input change between edges has no effect until the next edge, and outputs present the code sampled at the most recent edge.
- R5: The A weight, 512 times the number of ones in seg_a_o plus the value of lsb_a_o, equals the registered code. The B weight equals 16383 minus that code. Code 16383 gives A 16383 and B 0, code 8192 gives A 8192 and B 8191, and code 0 gives A 0 and B 16383.
- R6: While sleep_i is 1 at a rising edge, all outputs keep their previous value. The first rising edge with sleep_i at 0 captures the current code.
- R7: A rising edge with rst at 1 loads seg_a_o = 0 and lsb_a_o = 0, with all B lines at 1. Reset takes priority over sleep_i.
- R8: The code step from 511 to 512 turns on segment 0 and clears all nine binary lines in the same edge, moving the A weight by exactly one LSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; controls update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sleep_i | input | 1 | Active-high hold; freezes all controls |
| code_i | input | 14 | Straight-binary sample, bit 13 is the MSB |
| seg_a_o | output | 31 | Thermometer segment controls steering to output A |
| seg_b_o | output | 31 | Complementary segment controls steering to output B |
| lsb_a_o | output | 9 | Binary-weighted controls steering to output A |
| lsb_b_o | output | 9 | Complementary binary controls steering to output B |

## Verification
Reset and sleep can act in the same edge, and so can the release of sleep and a change of code. The bench loads a non-zero code, then raises reset while sleep is still high, and expects the all-zeros state: reset must win over the hold. It then changes the code while sleep is high and drops sleep with that same code waiting. The bench expects the frozen value until the release edge and the new code right after it, judged by the A and B weights from its own current model.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
    parameter int CODE_W = 14;
    parameter int MSB_W  = 5;
    localparam int LSB_W = CODE_W - MSB_W;
    localparam int SEG_N = (1 << MSB_W) - 1;

    typedef struct packed {
        logic [SEG_N-1:0] seg_a;
        logic [SEG_N-1:0] seg_b;
        logic [LSB_W-1:0] lsb_a;
        logic [LSB_W-1:0] lsb_b;
    } ctrl_t;
endpackage

// File: rtl/segdac_thermo.sv
module segdac_thermo #(
    parameter int BIN_W = 5,
    localparam int OUT_N = (1 << BIN_W) - 1
) (
    input  logic [BIN_W-1:0] bin_i,
    output logic [OUT_N-1:0] therm_o
);
    // Line k is lit when the coarse value exceeds k.
    for (genvar k = 0; k < OUT_N; k++) begin : g_line
        assign therm_o[k] = (bin_i > BIN_W'(k));
    end
endmodule

// File: rtl/segdac_pair.sv
module segdac_pair #(
    parameter int W = 9
) (
    input  logic [W-1:0] on_i,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o
);
    // One switch pair per line: a source feeds either A or B, never both.
    for (genvar i = 0; i < W; i++) begin : g_sw
        assign a_o[i] = on_i[i];
        assign b_o[i] = ~on_i[i];
    end
endmodule

// File: rtl/segdac_decoder.sv
module segdac_decoder
    import segdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [SEG_N-1:0]  seg_a_o,
    output logic [SEG_N-1:0]  seg_b_o,
    output logic [LSB_W-1:0]  lsb_a_o,
    output logic [LSB_W-1:0]  lsb_b_o
);
    localparam ctrl_t IDLE = '{seg_a: '0, seg_b: '1, lsb_a: '0, lsb_b: '1};

    logic [SEG_N-1:0] therm;
    logic [SEG_N-1:0] seg_a_n, seg_b_n;
    logic [LSB_W-1:0] lsb_a_n, lsb_b_n;
    ctrl_t            st_d, st_q;

    segdac_thermo #(.BIN_W(MSB_W)) u_thermo (
        .bin_i   (code_i[CODE_W-1:LSB_W]),
        .therm_o (therm)
    );

    segdac_pair #(.W(SEG_N)) u_seg_pair (
        .on_i (therm),
        .a_o  (seg_a_n),
        .b_o  (seg_b_n)
    );

    segdac_pair #(.W(LSB_W)) u_lsb_pair (
        .on_i (code_i[LSB_W-1:0]),
        .a_o  (lsb_a_n),
        .b_o  (lsb_b_n)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = IDLE;
        end else if (!sleep_i) begin
            st_d.seg_a = seg_a_n;
            st_d.seg_b = seg_b_n;
            st_d.lsb_a = lsb_a_n;
            st_d.lsb_b = lsb_b_n;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign seg_a_o = st_q.seg_a;
    assign seg_b_o = st_q.seg_b;
    assign lsb_a_o = st_q.lsb_a;
    assign lsb_b_o = st_q.lsb_b;

    a_r1_seg_count: assert property (@(posedge clk) disable iff (rst)
        !sleep_i |=> ($countones(seg_a_o) == int'($past(code_i[CODE_W-1:LSB_W]))));

    a_r1_contiguous: assert property (@(posedge clk) disable iff (rst)
        ((seg_a_o & (seg_a_o + 1'b1)) == '0));

    a_r2_lsb_pass: assert property (@(posedge clk) disable iff (rst)
        !sleep_i |=> (lsb_a_o == $past(code_i[LSB_W-1:0])));

    a_r3_complement: assert property (@(posedge clk) disable iff (rst)
        !sleep_i |=> ((seg_b_o == ~seg_a_o) && (lsb_b_o == ~lsb_a_o)));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        sleep_i |=> ($stable(seg_a_o) && $stable(seg_b_o) &&
                     $stable(lsb_a_o) && $stable(lsb_b_o)));

    a_r7_reset_idle: assert property (@(posedge clk)
        rst |=> ((seg_a_o == '0) && (lsb_a_o == '0) &&
                 (seg_b_o == '1) && (lsb_b_o == '1)));
endmodule

// File: tb/segdac_decoder_tb.sv
`timescale 1ns/1ps
module segdac_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        sleep_i;
    logic [13:0] code_i;
    logic [30:0] seg_a_o, seg_b_o;
    logic [8:0]  lsb_a_o, lsb_b_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    segdac_decoder dut_i (
        .clk     (clk),
        .rst     (rst),
        .sleep_i (sleep_i),
        .code_i  (code_i),
        .seg_a_o (seg_a_o),
        .seg_b_o (seg_b_o),
        .lsb_a_o (lsb_a_o),
        .lsb_b_o (lsb_b_o)
    );

    // {code, expected active segments, expected binary part}
    localparam logic [27:0] VEC [10] = '{
        {14'h3FFF, 5'd31, 9'd511},
        {14'h2000, 5'd16, 9'd0},
        {14'h0000, 5'd0,  9'd0},
        {14'h01FF, 5'd0,  9'd511},
        {14'h0200, 5'd1,  9'd0},
        {14'h3E00, 5'd31, 9'd0},
        {14'h0001, 5'd0,  9'd1},
        {14'h2AAA, 5'd21, 9'd170},
        {14'h1555, 5'd10, 9'd341},
        {14'h1FFF, 5'd15, 9'd511}
    };

    // Behavioural current model in LSB units
    function automatic int wt_a();
        return 512 * $countones(seg_a_o) + int'(lsb_a_o);
    endfunction
    function automatic int wt_b();
        return 512 * $countones(seg_b_o) + int'(lsb_b_o);
    endfunction
    function automatic bit thermo_ok();
        return (seg_a_o & (seg_a_o + 31'd1)) == 31'd0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_code(input string req, input int code);
        check(wt_a() == code, {req, " A weight (R5)"}, wt_a(), code);
        check(wt_b() == 16383 - code, {req, " B weight (R5)"}, wt_b(), 16383 - code);
        check(seg_b_o == ~seg_a_o && lsb_b_o == ~lsb_a_o, {req, " complement R3"},
              int'(seg_b_o == ~seg_a_o), 1);
    endtask

    // drive at negedge, sample at the following negedge (one posedge between)
    task automatic step(input bit r, input bit s, input logic [13:0] c);
        rst = r; sleep_i = s; code_i = c;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sleep_i = 1'b0; code_i = 14'h1234;
        @(negedge clk);
        step(1'b1, 1'b0, 14'h1234);
        // R7 reset state
        check(seg_a_o == '0 && lsb_a_o == '0 && seg_b_o == '1 && lsb_b_o == '1,
              "R7 reset idle", wt_a(), 0);

        // Table walk: R1, R2, R5
        for (int i = 0; i < 10; i++) begin
            step(1'b0, 1'b0, VEC[i][27:14]);
            check($countones(seg_a_o) == int'(VEC[i][13:9]) && thermo_ok(),
                  "R1 segment count", $countones(seg_a_o), int'(VEC[i][13:9]));
            check(lsb_a_o == VEC[i][8:0], "R2 binary pass", int'(lsb_a_o), int'(VEC[i][8:0]));
            check_code("table", int'(VEC[i][27:14]));
        end

        // Exhaustive sweep of every code
        for (int c = 0; c < 16384; c++) begin
            step(1'b0, 1'b0, 14'(c));
            check(wt_a() == c && wt_b() == 16383 - c, "R5 sweep", wt_a(), c);
        end

        // R8 major transition 511 -> 512
        step(1'b0, 1'b0, 14'd511);
        check(seg_a_o == '0 && lsb_a_o == 9'h1FF, "R8 before step", wt_a(), 511);
        step(1'b0, 1'b0, 14'd512);
        check(seg_a_o == 31'd1 && lsb_a_o == '0, "R8 after step", wt_a(), 512);

        // R4 mid-cycle change has no effect until the edge
        step(1'b0, 1'b0, 14'd1000);
        code_i = 14'd9000;
        #2;
        check(wt_a() == 1000, "R4 no change between edges", wt_a(), 1000);
        @(negedge clk);
        check(wt_a() == 9000, "R4 update on edge", wt_a(), 9000);

        // R6 sleep holds, release captures on first edge
        step(1'b0, 1'b1, 14'd3);
        check(wt_a() == 9000, "R6 hold 1", wt_a(), 9000);
        step(1'b0, 1'b1, 14'd16000);
        check(wt_a() == 9000, "R6 hold 2", wt_a(), 9000);
        check_code("R6 held", 9000);
        step(1'b0, 1'b0, 14'd16000);
        check(wt_a() == 16000, "R6 release", wt_a(), 16000);

        // R7 reset beats sleep in the same edge
        step(1'b0, 1'b0, 14'h2AAA);
        step(1'b1, 1'b1, 14'h3FFF);
        check(wt_a() == 0 && wt_b() == 16383, "R7 reset over sleep", wt_a(), 0);

        // Random sequence with random sleep, tracked by a bench-side model
        begin
            int held = 0;
            void'($urandom(7));
            for (int i = 0; i < 2000; i++) begin
                logic [13:0] c = 14'($urandom);
                bit s = ($urandom % 4) == 0;
                step(1'b0, s, c);
                if (!s) held = int'(c);
                check(wt_a() == held && wt_b() == 16383 - held && thermo_ok(),
                      "R6 random", wt_a(), held);
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule